// File: doc/BRIEF.md
# Interrupt Controller Command Decoder

This block is the write-side front end of an eight-channel programmable interrupt controller. A processor writes bytes to it through a strobe, a single address bit and an 8-bit data bus. The block first collects a variable-length set-up sequence of two to four words and holds the mode fields it contains. It then becomes ready and sorts each later write into one of four kinds: a channel mask load, an end-of-interrupt or rotation command, a read-select, poll or special-mask command, or a fresh set-up that starts over.

Everything it produces is registered. This includes the decoded mode fields, the channel mask, a one-cycle strobe that carries the command fields, a one-cycle poll strobe and a one-cycle clear strobe that the priority core uses to reset its in-service state and priority order. The same address bit also drives a registered read path. That path returns the mask, or whichever of the request and in-service registers the last select command chose.

Top module: `pic_cmd_decoder`

## Requirements
- R1: After a synchronous reset, `ready` is 0. All mode fields, the mask, `spec_mask` and every strobe are 0, and reads with `a0`=0 return the request register.
- R2: A write with `a0`=0 and `din[4]`=1 restarts set-up from any state. It captures bit0 as need-fourth-word, bit1 as `single_mode`, bit2 as `call_iv4` and bit3 as `trig_level`. It clears the mask, `slave_map`, the fourth-word fields and `spec_mask`, returns the read select to the request register, and raises `init_clr` for exactly the next cycle.
- R3: The first `a0`=1 write after a restart is stored whole in `vec_hi`. In vectored mode, bits 7:3 of this byte form the vector base.
- R4: When `single_mode` is 0, the next `a0`=1 write is stored in `slave_map`. When `single_mode` is 1, this word is skipped.
- R5: Only when the restart word had bit0 set, the next `a0`=1 write sets the fourth-word fields: bit0 `vec_mode`, bit1 `auto_eoi`, bits 3:2 `buf_mode` and bit4 `sfn_mode`. These fields stay 0 otherwise.
- R6: `ready` rises on the edge after the last required set-up word. Before any set-up, writes other than a restart change nothing.
- R7: While ready, an `a0`=1 write loads `irq_mask` (1 = channel masked). The mask changes on no other write except a restart.
- R8: While ready, an `a0`=0 write with `din[4:3]`=00 raises `cmd_vld` for one cycle. With it, `cmd_rot`=bit7, `cmd_sel`=bit6, `cmd_eoi`=bit5 and `cmd_lvl`=bits 2:0, and these fields hold until the next such command.
- R9: While ready, an `a0`=0 write with `din[4:3]`=01 is a select command. Bits 1:0 = 10 choose the request register, 11 choose the in-service register, and 0x keeps the current choice.
- R10: In a select command, bit6=1 with bit5=1 sets `spec_mask` and bit6=1 with bit5=0 clears it. With bit6=0, `spec_mask` is unchanged.
- R11: A select command with bit2=1 raises `poll_req` for exactly one cycle.
- R12: `dout` is registered. It shows the mask when `a0` was 1 in the previous cycle, and otherwise the selected request or in-service input as it stood in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | Write strobe, one cycle per byte |
| a0 | input | 1 | Address bit for both writes and reads |
| din | input | 8 | Write data |
| irr_in | input | 8 | Request register from the priority core |
| isr_in | input | 8 | In-service register from the priority core |
| dout | output | 8 | Registered read data |
| ready | output | 1 | Set-up complete |
| init_clr | output | 1 | One-cycle clear of in-service state and priority |
| trig_level | output | 1 | Level-triggered inputs |
| single_mode | output | 1 | No cascade |
| call_iv4 | output | 1 | Call address interval of 4 |
| vec_hi | output | 8 | Second set-up word (vector base) |
| slave_map | output | 8 | Third set-up word (slave map or ID) |
| vec_mode | output | 1 | Vectored processor mode |
| auto_eoi | output | 1 | Automatic end of interrupt |
| buf_mode | output | 2 | Buffer mode field |
| sfn_mode | output | 1 | Special fully nested mode |
| irq_mask | output | 8 | Channel mask |
| spec_mask | output | 1 | Special mask mode |
| cmd_vld | output | 1 | Command strobe |
| cmd_rot | output | 1 | Command rotate bit |
| cmd_sel | output | 1 | Command specific-level bit |
| cmd_eoi | output | 1 | Command end-of-interrupt bit |
| cmd_lvl | output | 3 | Command level |
| poll_req | output | 1 | One-cycle poll strobe |

## Verification
One select command can carry a special-mask change, a poll request and a read-select change at the same time. The bench writes such a byte and checks that `spec_mask`, `poll_req` and the next `dout` each move on the expected edge. A mask write can also land in the same cycle as a mask read. The bench holds `a0`=1 across the write and expects `dout` to show the old mask one cycle and the new mask the next. A randomized phase then mixes restarts, commands and reads, and a behavioural model is compared against every output on every clock.

// File: rtl/pic_cmd_pkg.sv
package pic_cmd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_W2   = 3'd1,
    ST_W3   = 3'd2,
    ST_W4   = 3'd3,
    ST_RDY  = 3'd4
  } seq_st_t;

  typedef struct packed {
    logic       vec_mode;
    logic       auto_eoi;
    logic [1:0] buf_mode;
    logic       sfn_mode;
  } w4_t;

  localparam int RESTART_BIT = 4;
endpackage

// File: rtl/pic_init_seq.sv
module pic_init_seq
  import pic_cmd_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic          a0,
  input  logic [DW-1:0] din,
  output logic          ready,
  output logic          init_clr,
  output logic          trig_level,
  output logic          single_mode,
  output logic          call_iv4,
  output logic [DW-1:0] vec_hi,
  output logic [DW-1:0] slave_map,
  output w4_t           w4
);
  seq_st_t st;
  logic    need4;
  logic    restart;
  logic    data_wr;

  assign restart = wr && !a0 && din[RESTART_BIT];
  assign data_wr = wr && a0;

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      ready       <= 1'b0;
      init_clr    <= 1'b0;
      need4       <= 1'b0;
      trig_level  <= 1'b0;
      single_mode <= 1'b0;
      call_iv4    <= 1'b0;
      vec_hi      <= '0;
      slave_map   <= '0;
      w4          <= '0;
    end else begin
      init_clr <= restart;
      if (restart) begin
        st          <= ST_W2;
        ready       <= 1'b0;
        need4       <= din[0];
        single_mode <= din[1];
        call_iv4    <= din[2];
        trig_level  <= din[3];
        slave_map   <= '0;
        w4          <= '0;
      end else if (data_wr) begin
        case (st)
          ST_W2: begin
            vec_hi <= din;
            if (!single_mode) st <= ST_W3;
            else if (need4) st <= ST_W4;
            else begin
              st    <= ST_RDY;
              ready <= 1'b1;
            end
          end
          ST_W3: begin
            slave_map <= din;
            if (need4) st <= ST_W4;
            else begin
              st    <= ST_RDY;
              ready <= 1'b1;
            end
          end
          ST_W4: begin
            w4.vec_mode <= din[0];
            w4.auto_eoi <= din[1];
            w4.buf_mode <= din[3:2];
            w4.sfn_mode <= din[4];
            st          <= ST_RDY;
            ready       <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  AST_RESTART_ENTERS_W2: assert property (@(posedge clk) disable iff (rst)
    restart |=> (st == ST_W2 && !ready && init_clr)); // R2
  AST_READY_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (ready && !restart) |=> ready); // R6
  AST_CLR_IS_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
    init_clr |-> $past(restart)); // R2
  AST_W4_ONLY_WHEN_ASKED: assert property (@(posedge clk) disable iff (rst)
    (st == ST_W4) |-> need4); // R5
endmodule

// File: rtl/pic_ocw_dec.sv
module pic_ocw_dec
  import pic_cmd_pkg::*;
#(
  parameter int DW  = 8,
  parameter int LVW = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr,
  input  logic           a0,
  input  logic [DW-1:0]  din,
  input  logic           ready,
  output logic [DW-1:0]  irq_mask,
  output logic           spec_mask,
  output logic           rd_isr,
  output logic           cmd_vld,
  output logic           cmd_rot,
  output logic           cmd_sel,
  output logic           cmd_eoi,
  output logic [LVW-1:0] cmd_lvl,
  output logic           poll_req
);
  logic restart, mask_wr, ctl_wr, sel_wr;

  assign restart = wr && !a0 && din[RESTART_BIT];
  assign mask_wr = wr && a0 && ready;
  assign ctl_wr  = wr && !a0 && ready && din[4:3] == 2'b00;
  assign sel_wr  = wr && !a0 && ready && din[4:3] == 2'b01;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_mask  <= '0;
      spec_mask <= 1'b0;
      rd_isr    <= 1'b0;
      cmd_vld   <= 1'b0;
      cmd_rot   <= 1'b0;
      cmd_sel   <= 1'b0;
      cmd_eoi   <= 1'b0;
      cmd_lvl   <= '0;
      poll_req  <= 1'b0;
    end else begin
      cmd_vld  <= ctl_wr;
      poll_req <= sel_wr && din[2];
      if (restart) begin
        irq_mask  <= '0;
        spec_mask <= 1'b0;
        rd_isr    <= 1'b0;
      end else begin
        if (mask_wr) irq_mask <= din;
        if (ctl_wr) begin
          cmd_rot <= din[7];
          cmd_sel <= din[6];
          cmd_eoi <= din[5];
          cmd_lvl <= din[LVW-1:0];
        end
        if (sel_wr) begin
          if (din[1]) rd_isr <= din[0];
          if (din[6]) spec_mask <= din[5];
        end
      end
    end
  end

  AST_MASK_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable(irq_mask)); // R7
  AST_SMM_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable(spec_mask)); // R10
  AST_CMD_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
    cmd_vld |-> $past(wr && !a0 && ready)); // R8
  AST_POLL_FROM_SELECT: assert property (@(posedge clk) disable iff (rst)
    poll_req |-> $past(wr && !a0 && ready && din[2])); // R11
  AST_NOT_READY_NO_CMD: assert property (@(posedge clk) disable iff (rst)
    !ready |=> !(cmd_vld || poll_req)); // R6
endmodule

// File: rtl/pic_rd_mux.sv
module pic_rd_mux #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          a0,
  input  logic          rd_isr,
  input  logic [DW-1:0] irq_mask,
  input  logic [DW-1:0] irr_in,
  input  logic [DW-1:0] isr_in,
  output logic [DW-1:0] dout
);
  always_ff @(posedge clk) begin
    if (rst) dout <= '0;
    else if (a0) dout <= irq_mask;
    else if (rd_isr) dout <= isr_in;
    else dout <= irr_in;
  end

  AST_MASK_READBACK: assert property (@(posedge clk) disable iff (rst)
    a0 |=> (dout == $past(irq_mask))); // R12
endmodule

// File: rtl/pic_cmd_decoder.sv
module pic_cmd_decoder
  import pic_cmd_pkg::*;
#(
  parameter int DW  = 8,
  parameter int LVW = $clog2(DW)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_stb,
  input  logic           a0,
  input  logic [DW-1:0]  din,
  input  logic [DW-1:0]  irr_in,
  input  logic [DW-1:0]  isr_in,
  output logic [DW-1:0]  dout,
  output logic           ready,
  output logic           init_clr,
  output logic           trig_level,
  output logic           single_mode,
  output logic           call_iv4,
  output logic [DW-1:0]  vec_hi,
  output logic [DW-1:0]  slave_map,
  output logic           vec_mode,
  output logic           auto_eoi,
  output logic [1:0]     buf_mode,
  output logic           sfn_mode,
  output logic [DW-1:0]  irq_mask,
  output logic           spec_mask,
  output logic           cmd_vld,
  output logic           cmd_rot,
  output logic           cmd_sel,
  output logic           cmd_eoi,
  output logic [LVW-1:0] cmd_lvl,
  output logic           poll_req
);
  w4_t  w4;
  logic rd_isr;

  pic_init_seq #(.DW(DW)) u_seq (
    .clk(clk), .rst(rst), .wr(wr_stb), .a0(a0), .din(din),
    .ready(ready), .init_clr(init_clr), .trig_level(trig_level),
    .single_mode(single_mode), .call_iv4(call_iv4), .vec_hi(vec_hi),
    .slave_map(slave_map), .w4(w4)
  );

  assign vec_mode = w4.vec_mode;
  assign auto_eoi = w4.auto_eoi;
  assign buf_mode = w4.buf_mode;
  assign sfn_mode = w4.sfn_mode;

  pic_ocw_dec #(.DW(DW), .LVW(LVW)) u_ocw (
    .clk(clk), .rst(rst), .wr(wr_stb), .a0(a0), .din(din), .ready(ready),
    .irq_mask(irq_mask), .spec_mask(spec_mask), .rd_isr(rd_isr),
    .cmd_vld(cmd_vld), .cmd_rot(cmd_rot), .cmd_sel(cmd_sel),
    .cmd_eoi(cmd_eoi), .cmd_lvl(cmd_lvl), .poll_req(poll_req)
  );

  pic_rd_mux #(.DW(DW)) u_rd (
    .clk(clk), .rst(rst), .a0(a0), .rd_isr(rd_isr), .irq_mask(irq_mask),
    .irr_in(irr_in), .isr_in(isr_in), .dout(dout)
  );

  AST_SKIPPED_W4_ZERO: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && !a0 && din[4] && !din[0]) |=> (w4 == '0)); // R5
  AST_MASK_CLEARED_ON_RESTART: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && !a0 && din[4]) |=> (irq_mask == '0 && !spec_mask)); // R2
endmodule

// File: tb/sim_pic_cmd_decoder.sv
module sim_pic_cmd_decoder;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_stb = 1'b0;
  logic a0 = 1'b0;
  logic [7:0] din = 8'h00, irr_in = 8'h00, isr_in = 8'h00;
  logic [7:0] dout, vec_hi, slave_map, irq_mask;
  logic ready, init_clr, trig_level, single_mode, call_iv4;
  logic vec_mode, auto_eoi, sfn_mode, spec_mask;
  logic [1:0] buf_mode;
  logic cmd_vld, cmd_rot, cmd_sel, cmd_eoi, poll_req;
  logic [2:0] cmd_lvl;

  int vectors = 0;
  int miscompares = 0;
  bit armed = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pic_cmd_decoder u0 (.*);

  // behavioural reference model
  int m_st;  // 0 idle, 2 second word, 3 third word, 4 fourth word, 9 ready
  bit m_need4, m_rdisr;
  logic [7:0] e_dout, e_vec, e_slv, e_mask;
  bit e_ready, e_clr, e_lvlt, e_single, e_iv4, e_vm, e_aeoi, e_sfn, e_smm;
  bit e_vld, e_rot, e_sel, e_eoi, e_poll;
  logic [1:0] e_buf;
  logic [2:0] e_lvl;

  always @(posedge clk) begin
    armed <= 1'b1;
    if (rst) begin
      m_st = 0; m_need4 = 0; m_rdisr = 0;
      e_dout = 0; e_vec = 0; e_slv = 0; e_mask = 0;
      e_ready = 0; e_clr = 0; e_lvlt = 0; e_single = 0; e_iv4 = 0;
      e_vm = 0; e_aeoi = 0; e_sfn = 0; e_smm = 0; e_buf = 0;
      e_vld = 0; e_rot = 0; e_sel = 0; e_eoi = 0; e_lvl = 0; e_poll = 0;
    end else begin
      e_dout = a0 ? e_mask : (m_rdisr ? isr_in : irr_in);
      e_clr = 0; e_vld = 0; e_poll = 0;
      if (wr_stb && !a0 && din[4]) begin
        e_clr = 1; m_st = 2; e_ready = 0;
        m_need4 = din[0]; e_single = din[1]; e_iv4 = din[2]; e_lvlt = din[3];
        e_slv = 0; e_vm = 0; e_aeoi = 0; e_buf = 0; e_sfn = 0;
        e_mask = 0; e_smm = 0; m_rdisr = 0;
      end else if (wr_stb && a0) begin
        if (m_st == 9) e_mask = din;
        else if (m_st == 2) begin
          e_vec = din;
          m_st = !e_single ? 3 : (m_need4 ? 4 : 9);
        end else if (m_st == 3) begin
          e_slv = din;
          m_st = m_need4 ? 4 : 9;
        end else if (m_st == 4) begin
          e_vm = din[0]; e_aeoi = din[1]; e_buf = din[3:2]; e_sfn = din[4];
          m_st = 9;
        end
        e_ready = (m_st == 9);
      end else if (wr_stb && m_st == 9) begin
        if (din[4:3] == 2'b00) begin
          e_vld = 1; e_rot = din[7]; e_sel = din[6]; e_eoi = din[5]; e_lvl = din[2:0];
        end else begin
          if (din[1]) m_rdisr = din[0];
          if (din[6]) e_smm = din[5];
          e_poll = din[2];
        end
      end
    end
  end

  task automatic cmp(input string req, input logic [7:0] act, input logic [7:0] exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s at %0t: got %h expected %h", req, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (armed && !done) begin
      vectors++;
      cmp("R6 ready", {7'd0, ready}, {7'd0, e_ready});
      cmp("R2 init_clr", {7'd0, init_clr}, {7'd0, e_clr});
      cmp("R2 mode bits", {5'd0, trig_level, single_mode, call_iv4}, {5'd0, e_lvlt, e_single, e_iv4});
      cmp("R3 vec_hi", vec_hi, e_vec);
      cmp("R4 slave_map", slave_map, e_slv);
      cmp("R5 fourth word", {3'd0, sfn_mode, buf_mode, auto_eoi, vec_mode},
          {3'd0, e_sfn, e_buf, e_aeoi, e_vm});
      cmp("R7 irq_mask", irq_mask, e_mask);
      cmp("R8 cmd_vld", {7'd0, cmd_vld}, {7'd0, e_vld});
      cmp("R8 cmd fields", {2'd0, cmd_rot, cmd_sel, cmd_eoi, cmd_lvl},
          {2'd0, e_rot, e_sel, e_eoi, e_lvl});
      cmp("R10 spec_mask", {7'd0, spec_mask}, {7'd0, e_smm});
      cmp("R11 poll_req", {7'd0, poll_req}, {7'd0, e_poll});
      cmp("R12 R9 dout", dout, e_dout);
    end
  end

  task automatic wr(input logic addr, input logic [7:0] d);
    @(negedge clk); #1;
    wr_stb = 1'b1; a0 = addr; din = d;
    @(negedge clk); #1;
    wr_stb = 1'b0; din = 8'h00;
  endtask

  task automatic rd(input logic addr);
    @(negedge clk); #1;
    a0 = addr;
    @(negedge clk); #1;
  endtask

  initial begin
    #200_000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    irr_in = 8'h3C; isr_in = 8'hC1;
    repeat (3) @(negedge clk);
    #1 rst = 1'b0;                       // R1 reset state compared
    rd(1'b0);
    wr(1'b1, 8'hAA); rd(1'b1);           // R6 ignored before set-up
    wr(1'b0, 8'h05); wr(1'b0, 8'h0C);    // R6 no strobes before set-up
    wr(1'b0, 8'h13); wr(1'b1, 8'h48);    // R2 R3 single with fourth word
    wr(1'b1, 8'h1F);                     // R5
    wr(1'b1, 8'h5A); rd(1'b1);           // R7
    // R12 mask write while reading mask: old then new
    @(negedge clk); #1; a0 = 1'b1; wr_stb = 1'b1; din = 8'hC3;
    @(negedge clk); #1; wr_stb = 1'b0; din = 8'h00;
    @(negedge clk); #1;
    wr(1'b0, 8'hE5); wr(1'b0, 8'h20);    // R8
    wr(1'b0, 8'h0B); rd(1'b0);           // R9 in-service
    wr(1'b0, 8'h09); rd(1'b0);           // R9 unchanged
    wr(1'b0, 8'h0A); rd(1'b0);           // R9 request
    wr(1'b0, 8'h6F); rd(1'b0);           // R10 R11 R9 together
    wr(1'b0, 8'h28);                     // R10 ignored without enable
    wr(1'b0, 8'h48);                     // R10 clear
    wr(1'b0, 8'h18); wr(1'b1, 8'hF8);    // R2 R4 cascade, no fourth word
    wr(1'b1, 8'h84); wr(1'b1, 8'h11);
    wr(1'b0, 8'h11); wr(1'b0, 8'h1A);    // R2 restart mid-sequence
    wr(1'b1, 8'h20); wr(1'b1, 8'h77);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk); #1;
      irr_in = 8'($urandom); isr_in = 8'($urandom);
      wr_stb = ($urandom_range(0, 2) == 0);
      a0 = $urandom_range(0, 1);
      din = 8'($urandom);
      if (!a0 && $urandom_range(0, 9) != 0) din[4] = 1'b0;
      if (i % 700 == 350) rst = 1'b1; else rst = 1'b0;  // R1
    end
    @(negedge clk); #1; wr_stb = 1'b0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule